// File: doc/BRIEF.md
# Break-Before-Make Line Driver Gate Control

This block sits between a pulse pattern source and eight two-level line output stages plus one shutter output stage. Each channel takes one digital level and produces two gate enables, one for the transistor that pulls the output to the high rail and one for the transistor that pulls it to ground. The sense is inverting: a low input asks for a high output and a high input asks for a low output.

Every channel is a four-state machine with the states ST_OFF, ST_GAP, ST_HIGH and ST_LOW. ST_OFF turns both transistors off and is entered from any state whenever the channel's hold condition is true. The transition off_to_gap leaves ST_OFF once the hold clears. The transitions high_to_gap and low_to_gap fire when the requested level changes. The transitions gap_to_high and gap_to_low fire when the dead-time counter in ST_GAP expires, and they pick the side from the input level at that moment. The eight line channels, laid out as two groups of four, are held off while the supplies are not ready, while the tri-state request bit is set, or during power-down. The shutter channel is held off only during power-down. All channels are built from one identical state machine, so each has the same logic depth.

Top module: `ldrv_gate_ctrl`

## Requirements
- R1: Line channel i is controlled only by `line_in[i]` and drives only `line_hi_en[i]` and `line_lo_en[i]`. A change on one channel leaves the enables of the other seven unchanged.
- R2: Once settled, an input at 0 gives hi_en=1 and lo_en=0, and an input at 1 gives hi_en=0 and lo_en=1. This applies to the line and shutter channels alike.
- R3: The hi and lo enables of any channel are never 1 in the same cycle.
- R4: When `supply_ok`=0, `tri_req`=1 or `pwr_down`=1 is sampled at a clock edge, all sixteen line enables are 0 from that edge on, for as long as the condition lasts.
- R5: `supply_ok` and `tri_req` have no effect on the shutter enables.
- R6: The dead time L is `dead_cfg` clock cycles, or 1 when `dead_cfg`=0. After a level change is sampled at an edge, both enables of that channel stay 0 for exactly L cycles. The enable for the new side then rises.
- R7: When the hold condition clears, both enables stay 0 for L cycles. The side chosen by the input level at that time is then enabled.
- R8: With `pwr_down`=1, the shutter enables are also both 0.
- R9: During reset all enables are 0.
- R10: An input that changes again while the channel is in its dead time does not restart the gap. The level present when the gap expires selects the side.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| line_in | input | 8 | Line channel levels, group A in bits 3:0, group B in bits 7:4 |
| shut_in | input | 1 | Shutter channel level |
| supply_ok | input | 1 | Rails ready; 0 holds the line channels off |
| tri_req | input | 1 | Register tri-state bit; 1 holds the line channels off |
| pwr_down | input | 1 | Power-down; 1 holds every channel off |
| dead_cfg | input | 4 | Dead time in clock cycles (0 treated as 1) |
| line_hi_en | output | 8 | High-side gate enables of the line channels |
| line_lo_en | output | 8 | Low-side gate enables of the line channels |
| shut_hi_en | output | 1 | Shutter high-side gate enable |
| shut_lo_en | output | 1 | Shutter low-side gate enable |

## Verification
The bench uses the default parameters: two groups of four channels and a 4-bit dead-time field. With these values the shutter and line holds can be checked on every channel in one table. The directed tests set `dead_cfg` to 0, 3 and 4, which covers the zero-as-one rule and lets the gap be counted cycle by cycle, including a level that flips back in the middle of a gap. They also release tri-state and power-down to observe the gap that comes before any drive.

// File: rtl/ldrv_pkg.sv
package ldrv_pkg;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_GAP  = 2'd1,
        ST_HIGH = 2'd2,
        ST_LOW  = 2'd3
    } chan_state_e;

endpackage

// File: rtl/ldrv_hold_ctrl.sv
module ldrv_hold_ctrl #(
    parameter int DT_W = 4
) (
    input  logic            supply_ok,
    input  logic            tri_req,
    input  logic            pwr_down,
    input  logic [DT_W-1:0] dead_cfg,
    output logic            line_hold,
    output logic            shut_hold,
    output logic [DT_W-1:0] gap_len
);
    localparam logic [DT_W-1:0] ONE = DT_W'(1);

    always_comb begin
        line_hold = pwr_down | tri_req | ~supply_ok;
        shut_hold = pwr_down;
        gap_len   = (dead_cfg == '0) ? ONE : dead_cfg;
    end

endmodule

// File: rtl/ldrv_chan_fsm.sv
module ldrv_chan_fsm
    import ldrv_pkg::*;
#(
    parameter int DT_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            drv_in,
    input  logic            hold,
    input  logic [DT_W-1:0] gap_len,
    output logic            hi_en,
    output logic            lo_en
);
    localparam logic [DT_W-1:0] ONE = DT_W'(1);

    chan_state_e     st, st_nx;
    logic [DT_W-1:0] cnt, cnt_nx;
    logic            want_high;

    assign want_high = ~drv_in;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st  <= ST_OFF;
            cnt <= '0;
        end else begin
            st  <= st_nx;
            cnt <= cnt_nx;
        end
    end

    always_comb begin
        st_nx  = st;
        cnt_nx = cnt;
        if (hold) begin
            st_nx  = ST_OFF;
            cnt_nx = '0;
        end else begin
            unique case (st)
                ST_OFF: begin
                    st_nx  = ST_GAP;
                    cnt_nx = gap_len - ONE;
                end
                ST_GAP: begin
                    if (cnt == '0) begin
                        st_nx = want_high ? ST_HIGH : ST_LOW;
                    end else begin
                        cnt_nx = cnt - ONE;
                    end
                end
                ST_HIGH: begin
                    if (!want_high) begin
                        st_nx  = ST_GAP;
                        cnt_nx = gap_len - ONE;
                    end
                end
                ST_LOW: begin
                    if (want_high) begin
                        st_nx  = ST_GAP;
                        cnt_nx = gap_len - ONE;
                    end
                end
                default: begin
                    st_nx  = ST_OFF;
                    cnt_nx = '0;
                end
            endcase
        end
    end

    always_comb begin
        hi_en = 1'b0;
        lo_en = 1'b0;
        unique case (st)
            ST_HIGH: hi_en = 1'b1;
            ST_LOW:  lo_en = 1'b1;
            default: begin
                hi_en = 1'b0;
                lo_en = 1'b0;
            end
        endcase
    end

    // R3
    both_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(hi_en && lo_en));

    // R4
    hold_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> (!hi_en && !lo_en));

    // R2
    hi_sense_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hi_en |-> $past(!drv_in && !hold));

    // R2
    lo_sense_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lo_en |-> $past(drv_in && !hold));

    // R6
    hi_after_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hi_en) |-> $past(!hi_en && !lo_en));

    // R6
    lo_after_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lo_en) |-> $past(!hi_en && !lo_en));

endmodule

// File: rtl/ldrv_gate_ctrl.sv
module ldrv_gate_ctrl #(
    parameter int N_GRP = 2,
    parameter int GRP_W = 4,
    parameter int DT_W  = 4,
    localparam int NCH  = N_GRP * GRP_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NCH-1:0]  line_in,
    input  logic            shut_in,
    input  logic            supply_ok,
    input  logic            tri_req,
    input  logic            pwr_down,
    input  logic [DT_W-1:0] dead_cfg,
    output logic [NCH-1:0]  line_hi_en,
    output logic [NCH-1:0]  line_lo_en,
    output logic            shut_hi_en,
    output logic            shut_lo_en
);
    logic            line_hold;
    logic            shut_hold;
    logic [DT_W-1:0] gap_len;

    ldrv_hold_ctrl #(.DT_W(DT_W)) u_hold (
        .supply_ok (supply_ok),
        .tri_req   (tri_req),
        .pwr_down  (pwr_down),
        .dead_cfg  (dead_cfg),
        .line_hold (line_hold),
        .shut_hold (shut_hold),
        .gap_len   (gap_len)
    );

    for (genvar g = 0; g < N_GRP; g++) begin : g_grp
        for (genvar c = 0; c < GRP_W; c++) begin : g_ch
            localparam int IDX = g * GRP_W + c;
            ldrv_chan_fsm #(.DT_W(DT_W)) u_ch (
                .clk     (clk),
                .rst_n   (rst_n),
                .drv_in  (line_in[IDX]),
                .hold    (line_hold),
                .gap_len (gap_len),
                .hi_en   (line_hi_en[IDX]),
                .lo_en   (line_lo_en[IDX])
            );
        end
    end

    ldrv_chan_fsm #(.DT_W(DT_W)) u_shut (
        .clk     (clk),
        .rst_n   (rst_n),
        .drv_in  (shut_in),
        .hold    (shut_hold),
        .gap_len (gap_len),
        .hi_en   (shut_hi_en),
        .lo_en   (shut_lo_en)
    );

    // R8
    shut_pd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_down |=> (!shut_hi_en && !shut_lo_en));

    // R4
    line_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tri_req || !supply_ok) |=> ((line_hi_en | line_lo_en) == '0));

endmodule

// File: tb/sim_ldrv_gate_ctrl.sv
module sim_ldrv_gate_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] line_in = 8'h00;
    logic       shut_in = 1'b0;
    logic       supply_ok = 1'b0;
    logic       tri_req = 1'b0;
    logic       pwr_down = 1'b0;
    logic [3:0] dead_cfg = 4'd3;
    logic [7:0] line_hi_en, line_lo_en;
    logic       shut_hi_en, shut_lo_en;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    ldrv_gate_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .line_in(line_in), .shut_in(shut_in),
        .supply_ok(supply_ok), .tri_req(tri_req), .pwr_down(pwr_down),
        .dead_cfg(dead_cfg), .line_hi_en(line_hi_en), .line_lo_en(line_lo_en),
        .shut_hi_en(shut_hi_en), .shut_lo_en(shut_lo_en)
    );

    // fields: line_in, shut_in, supply_ok, tri_req, pwr_down,
    //         exp_hi, exp_lo, exp_shut_hi, exp_shut_lo
    localparam int NV = 8;
    localparam logic [29:0] VEC [NV] = '{
        {8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 8'hFF, 8'h00, 1'b1, 1'b0},
        {8'hFF, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00, 8'hFF, 1'b0, 1'b1},
        {8'hA5, 1'b0, 1'b1, 1'b0, 1'b0, 8'h5A, 8'hA5, 1'b1, 1'b0},
        {8'h0F, 1'b1, 1'b1, 1'b1, 1'b0, 8'h00, 8'h00, 1'b0, 1'b1},
        {8'h3C, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00, 1'b1, 1'b0},
        {8'h3C, 1'b0, 1'b1, 1'b0, 1'b0, 8'hC3, 8'h3C, 1'b1, 1'b0},
        {8'h3C, 1'b0, 1'b1, 1'b0, 1'b1, 8'h00, 8'h00, 1'b0, 1'b0},
        {8'h81, 1'b1, 1'b1, 1'b0, 1'b0, 8'h7E, 8'h81, 1'b0, 1'b1}
    };

    task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wait_neg(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #2000000;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R9: reset state
        wait_neg(3);
        chk("R9 line enables in reset", {line_hi_en, line_lo_en}, 16'h0000);
        chk("R9 shutter enables in reset", {14'd0, shut_hi_en, shut_lo_en}, 16'h0000);
        rst_n = 1'b1;

        // table walk, dead_cfg = 3
        for (int i = 0; i < NV; i++) begin
            {line_in, shut_in, supply_ok, tri_req, pwr_down} = VEC[i][29:18];
            wait_neg(8);
            chk("R2/R4/R5/R8 line table", {line_hi_en, line_lo_en}, VEC[i][17:2]);
            chk("R2/R5/R8 shutter table", {14'd0, shut_hi_en, shut_lo_en}, {14'd0, VEC[i][1:0]});
        end

        // R6 / R1: exact gap of 4 on channel 2
        dead_cfg = 4'd4; line_in = 8'h00; shut_in = 1'b0;
        supply_ok = 1'b1; tri_req = 1'b0; pwr_down = 1'b0;
        wait_neg(10);
        line_in[2] = 1'b1;
        for (int k = 1; k <= 4; k++) begin
            wait_neg(1);
            chk("R6 gap cycle both off", {14'd0, line_hi_en[2], line_lo_en[2]}, 16'h0000);
            chk("R1 other channels unchanged", {line_hi_en, line_lo_en}, {8'hFB, 8'h00});
        end
        wait_neg(1);
        chk("R6 new side after gap", {line_hi_en, line_lo_en}, {8'hFB, 8'h04});

        // R6: dead_cfg 0 acts as 1
        dead_cfg = 4'd0;
        line_in = 8'h00;
        wait_neg(1);
        chk("R6 zero cfg gap", {line_hi_en, line_lo_en}, {8'hFB, 8'h00});
        wait_neg(1);
        chk("R6 zero cfg drive", {line_hi_en, line_lo_en}, {8'hFF, 8'h00});

        // R10: flip back during gap, no restart
        dead_cfg = 4'd4;
        line_in = 8'h10;
        wait_neg(2);
        line_in = 8'h00;
        wait_neg(2);
        chk("R10 still in gap", {line_hi_en, line_lo_en}, {8'hEF, 8'h00});
        wait_neg(1);
        chk("R10 level at expiry wins", {line_hi_en, line_lo_en}, {8'hFF, 8'h00});

        // R7: leave tri-state, gap of 3
        dead_cfg = 4'd3;
        tri_req = 1'b1;
        line_in = 8'hF0;
        wait_neg(1);
        chk("R4 tri-state next edge", {line_hi_en, line_lo_en}, 16'h0000);
        wait_neg(3);
        tri_req = 1'b0;
        wait_neg(3);
        chk("R7 gap after tri-state release", {line_hi_en, line_lo_en}, 16'h0000);
        wait_neg(1);
        chk("R7 drive after release", {line_hi_en, line_lo_en}, {8'h0F, 8'hF0});

        // R8 / R7: power-down on shutter and release
        shut_in = 1'b1;
        wait_neg(6);
        chk("R2 shutter low", {14'd0, shut_hi_en, shut_lo_en}, 16'h0001);
        pwr_down = 1'b1;
        wait_neg(1);
        chk("R8 shutter off in power-down", {14'd0, shut_hi_en, shut_lo_en}, 16'h0000);
        pwr_down = 1'b0;
        wait_neg(3);
        chk("R7 shutter gap after power-down", {14'd0, shut_hi_en, shut_lo_en}, 16'h0000);
        wait_neg(1);
        chk("R7 shutter drive after power-down", {14'd0, shut_hi_en, shut_lo_en}, 16'h0001);

        // R5: supply loss leaves shutter driving
        supply_ok = 1'b0;
        wait_neg(2);
        chk("R5 shutter ignores supply_ok", {14'd0, shut_hi_en, shut_lo_en}, 16'h0001);
        chk("R4 lines off on supply loss", {line_hi_en, line_lo_en}, 16'h0000);

        // R9: reset again mid-operation
        rst_n = 1'b0;
        wait_neg(1);
        chk("R9 reset clears all", {line_hi_en, line_lo_en, 14'd0, shut_hi_en, shut_lo_en} == 32'd0 ? 16'd0 : 16'd1, 16'd0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule